// File: doc/BRIEF.md
# Clocked Serial Receiver with Overrun Lockout

This block receives 8-bit frames over a two-wire clocked synchronous link (serial clock plus serial data). The serial clock is either generated by the block from the system clock through a fixed divider, or taken from an external pin through a synchronizer. Every rising serial clock edge samples one bit into a shift register, least significant bit first. Optionally a parity bit, then a stop bit, follow the data bits.

At the end of a frame the byte moves into a holding register and a full flag is raised. If the previous byte is still held, the new byte is dropped and an overrun is flagged. Parity and stop-bit faults set their own error flags. After any error the receiver freezes completely until software has cleared every error flag and the full flag. Each flag is cleared by its own one-cycle strobe. Two level interrupt requests, one for received data and one for errors, share a single enable.

Top module: `clocked_serial_rx`

## Requirements
- R1: After reset, `rd_data` is 0, all four flags are 0, `sclk_out` is 0 and both interrupt requests are 0.
- R2: A frame is 8 data bits sent least significant bit first. When `par_en` is 1 a parity bit follows. When `stop_en` is 1 a stop bit comes last.
- R3: When a frame ends with `full`=0 and no parity or stop fault, `rd_data` takes the received byte and `full` becomes 1.
- R4: `irq_rx` is high exactly when `rie` is 1 and `full` is 1.
- R5: When a frame ends while `full` is 1, `ovr` becomes 1. In that case `full` stays 1 and `rd_data` keeps its old byte.
- R6: `irq_err` is high exactly when `rie` is 1 and any of `ovr`, `fer`, `per` is 1.
- R7: After an error is flagged, no frame is accepted until `ovr`, `fer`, `per` and `full` are all 0.
- R8: Each flag falls only on its own clear strobe (`clr_full`, `clr_ovr`, `clr_fer`, `clr_per`). Waiting, or strobing another flag's clear, leaves it set.
- R9: With `ext_sel`=0, `sclk_out` toggles every CLK_DIV system clocks while `rx_en`=1 and the receiver is not locked, and holds 0 otherwise. A bit is sampled on each of its rising edges.
- R10: With `ext_sel`=1, `sclk_in` passes through a two-flop synchronizer, and one bit is sampled per rising edge seen.
- R11: With `par_en`=1, the count of ones over the data bits and the parity bit must be odd when `par_odd`=1, or even when `par_odd`=0. On a mismatch with `full`=0, `per` becomes 1 and `rd_data` and `full` are unchanged.
- R12: With `stop_en`=1, a stop bit of 0 with `full`=0 sets `fer`, and `rd_data` and `full` are unchanged.
- R13: Setting `rx_en` to 0 discards a partly received frame. `rd_data` and all flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable |
| ext_sel | input | 1 | 1 selects the external serial clock |
| sclk_in | input | 1 | External serial clock |
| sclk_out | output | 1 | Generated serial clock |
| sdata_in | input | 1 | Serial data |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| stop_en | input | 1 | Stop bit present and checked |
| rie | input | 1 | Interrupt enable for both requests |
| clr_full | input | 1 | Clear strobe for `full` |
| clr_ovr | input | 1 | Clear strobe for `ovr` |
| clr_fer | input | 1 | Clear strobe for `fer` |
| clr_per | input | 1 | Clear strobe for `per` |
| rd_data | output | 8 | Received byte |
| full | output | 1 | Byte held, not yet released |
| ovr | output | 1 | Overrun flag |
| fer | output | 1 | Stop-bit (framing) error flag |
| per | output | 1 | Parity error flag |
| irq_rx | output | 1 | Receive interrupt request |
| irq_err | output | 1 | Error interrupt request |

## Verification
The assertions assume three things about the inputs:
- `par_en` and `stop_en` change only while no frame is in progress.
- Serial data is stable for at least three system clocks after each rising serial clock edge.
- The external clock's half period is well over three system clocks.

The bench changes the frame options only while `rx_en` is 0. It moves data only after a falling serial clock edge, and it drives the external clock with eight-cycle half periods. Random frames mix both clock sources, options, injected faults and missed reads. Before each frame the bench clears any error state, so the generated clock can never be stalled halfway through a frame.

// File: rtl/csrx_pkg.sv
package csrx_pkg;
  parameter int unsigned DATA_W = 8;
  localparam int unsigned IDX_W = $clog2(DATA_W);
  localparam int unsigned CNT_W = $clog2(DATA_W + 2);

  typedef logic [DATA_W-1:0] data_t;

  typedef struct packed {
    data_t data;
    logic  pbit;
    logic  sbit;
  } frame_t;

  // Index of the final bit in a frame for the chosen options
  function automatic logic [CNT_W-1:0] last_index(input logic p_on, input logic s_on);
    return CNT_W'(DATA_W - 1) + CNT_W'(p_on) + CNT_W'(s_on);
  endfunction

  // True when data plus parity bit do not give the requested sense
  function automatic logic parity_bad(input data_t d, input logic pbit, input logic odd);
    return ((^d) ^ pbit) != odd;
  endfunction
endpackage

// File: rtl/csrx_clkgen.sv
module csrx_clkgen #(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_sel,
  input  logic run,
  input  logic sclk_in,
  output logic sclk_out,
  output logic bit_tick
);
  localparam int unsigned DIV_W = $clog2(CLK_DIV + 1);

  logic [DIV_W-1:0] div_cnt;
  logic             sclk_q;
  logic             int_tick;
  logic [2:0]       sync_q;
  logic             int_run;
  logic             ext_rise;

  assign int_run = run & ~ext_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt  <= '0;
      sclk_q   <= 1'b0;
      int_tick <= 1'b0;
    end else if (!int_run) begin
      div_cnt  <= '0;
      sclk_q   <= 1'b0;
      int_tick <= 1'b0;
    end else begin
      int_tick <= 1'b0;
      if (div_cnt == DIV_W'(CLK_DIV - 1)) begin
        div_cnt  <= '0;
        sclk_q   <= ~sclk_q;
        int_tick <= ~sclk_q;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 3'b111;
    else        sync_q <= {sync_q[1:0], sclk_in};
  end

  assign ext_rise = sync_q[1] & ~sync_q[2];
  assign sclk_out = sclk_q;
  assign bit_tick = ext_sel ? (ext_rise & run) : int_tick;

  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !int_run |=> !sclk_out); // R9
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick); // R10
endmodule

// File: rtl/csrx_shifter.sv
module csrx_shifter
  import csrx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en,
  input  logic   tick,
  input  logic   sdata,
  input  logic   par_en,
  input  logic   stop_en,
  output frame_t frame,
  output logic   done
);
  logic [CNT_W-1:0] idx;
  logic [CNT_W-1:0] last;

  assign last = last_index(par_en, stop_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= '0;
      frame <= '0;
      done  <= 1'b0;
    end else if (!en) begin
      idx   <= '0;
      frame <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        if (idx < CNT_W'(DATA_W))
          frame.data[idx[IDX_W-1:0]] <= sdata;
        else if (idx == CNT_W'(DATA_W) && par_en)
          frame.pbit <= sdata;
        else
          frame.sbit <= sdata;
        if (idx == last) begin
          idx  <= '0;
          done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  AST_HALT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (idx == '0) && !done); // R13
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(par_en) && $stable(stop_en) |-> idx <= last); // R2
endmodule

// File: rtl/csrx_flags.sv
module csrx_flags
  import csrx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   done,
  input  frame_t frame,
  input  logic   par_en,
  input  logic   par_odd,
  input  logic   stop_en,
  input  logic   clr_full,
  input  logic   clr_ovr,
  input  logic   clr_fer,
  input  logic   clr_per,
  output data_t  data_q,
  output logic   full,
  output logic   ovr,
  output logic   fer,
  output logic   per,
  output logic   lock
);
  logic  ev_ovr, ev_per, ev_fer, ev_load, ev_err, all_clear;
  data_t fr_data;

  assign fr_data   = frame.data;
  assign ev_ovr    = done & full;
  assign ev_per    = done & ~full & par_en & parity_bad(frame.data, frame.pbit, par_odd);
  assign ev_fer    = done & ~full & stop_en & ~frame.sbit;
  assign ev_load   = done & ~full & ~ev_per & ~ev_fer;
  assign ev_err    = ev_ovr | ev_per | ev_fer;
  assign all_clear = ~full & ~ovr & ~fer & ~per;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full   <= 1'b0;
      ovr    <= 1'b0;
      fer    <= 1'b0;
      per    <= 1'b0;
      lock   <= 1'b0;
    end else begin
      if (ev_load) data_q <= frame.data;
      if (ev_load)       full <= 1'b1;
      else if (clr_full) full <= 1'b0;
      if (ev_ovr)        ovr <= 1'b1;
      else if (clr_ovr)  ovr <= 1'b0;
      if (ev_fer)        fer <= 1'b1;
      else if (clr_fer)  fer <= 1'b0;
      if (ev_per)        per <= 1'b1;
      else if (clr_per)  per <= 1'b0;
      if (ev_err)         lock <= 1'b1;
      else if (all_clear) lock <= 1'b0;
    end
  end

  AST_LOAD_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    done && !full && !ev_per && !ev_fer |=> full && data_q == $past(fr_data)); // R3
  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done && full |=> full && ovr && $stable(data_q)); // R5
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    lock && !all_clear |=> lock); // R7
  AST_PAR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_per |=> per && $stable(data_q) && !full); // R11
  AST_STOP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fer |=> fer && $stable(data_q) && !full); // R12
  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    full && !clr_full |=> full); // R8
endmodule

// File: rtl/clocked_serial_rx.sv
module clocked_serial_rx
  import csrx_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              ext_sel,
  input  logic              sclk_in,
  output logic              sclk_out,
  input  logic              sdata_in,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              stop_en,
  input  logic              rie,
  input  logic              clr_full,
  input  logic              clr_ovr,
  input  logic              clr_fer,
  input  logic              clr_per,
  output logic [DATA_W-1:0] rd_data,
  output logic              full,
  output logic              ovr,
  output logic              fer,
  output logic              per,
  output logic              irq_rx,
  output logic              irq_err
);
  logic   lock, run, bit_tick, frame_done;
  frame_t frame;

  assign run = rx_en & ~lock;

  csrx_clkgen #(.CLK_DIV(CLK_DIV)) clkgen_i (
    .clk(clk), .rst_n(rst_n), .ext_sel(ext_sel), .run(run),
    .sclk_in(sclk_in), .sclk_out(sclk_out), .bit_tick(bit_tick)
  );

  csrx_shifter shifter_i (
    .clk(clk), .rst_n(rst_n), .en(run), .tick(bit_tick), .sdata(sdata_in),
    .par_en(par_en), .stop_en(stop_en), .frame(frame), .done(frame_done)
  );

  csrx_flags flags_i (
    .clk(clk), .rst_n(rst_n), .done(frame_done), .frame(frame),
    .par_en(par_en), .par_odd(par_odd), .stop_en(stop_en),
    .clr_full(clr_full), .clr_ovr(clr_ovr), .clr_fer(clr_fer), .clr_per(clr_per),
    .data_q(rd_data), .full(full), .ovr(ovr), .fer(fer), .per(per), .lock(lock)
  );

  assign irq_rx  = rie & full;
  assign irq_err = rie & (ovr | fer | per);

  AST_RX_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) && rie |-> irq_rx); // R4
  AST_ERR_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) && rie |-> irq_err); // R6
endmodule

// File: tb/clocked_serial_rx_tb_top.sv
module clocked_serial_rx_tb_top;
  localparam int DIV = 4;
  localparam int HP  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_en = 0, ext_sel = 1, sclk_in = 1, sdata_in = 0;
  logic par_en = 0, par_odd = 0, stop_en = 0, rie = 0;
  logic clr_full = 0, clr_ovr = 0, clr_fer = 0, clr_per = 0;
  logic sclk_out, full, ovr, fer, per, irq_rx, irq_err;
  logic [7:0] rd_data;
  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;

  // expected state
  logic [7:0] m_data = 0;
  logic m_full = 0, m_ovr = 0, m_fer = 0, m_per = 0;

  always #2 clk = ~clk;

  clocked_serial_rx #(.CLK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ext_sel(ext_sel), .sclk_in(sclk_in),
    .sclk_out(sclk_out), .sdata_in(sdata_in), .par_en(par_en), .par_odd(par_odd),
    .stop_en(stop_en), .rie(rie), .clr_full(clr_full), .clr_ovr(clr_ovr),
    .clr_fer(clr_fer), .clr_per(clr_per), .rd_data(rd_data), .full(full),
    .ovr(ovr), .fer(fer), .per(per), .irq_rx(irq_rx), .irq_err(irq_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic good_pbit(input logic [7:0] d, input logic odd);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += d[i];
    return odd ? (ones % 2 == 0) : (ones % 2 == 1);
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    clr_full = 1; clr_ovr = 1; clr_fer = 1; clr_per = 1;
    idle(1);
    clr_full = 0; clr_ovr = 0; clr_fer = 0; clr_per = 0;
    m_full = 0; m_ovr = 0; m_fer = 0; m_per = 0;
    idle(2);
  endtask

  // nbits: how many bits of the frame to send (for partial frames)
  task automatic send(input bit ext, input logic [7:0] d, input logic pb,
                      input logic sb, input int nbits);
    logic [9:0] bits;
    int len;
    len = 8 + par_en + stop_en;
    bits = {2'b00, d};
    if (par_en) bits[8] = pb;
    bits[8 + par_en] = stop_en ? sb : bits[8 + par_en];
    if (nbits < len) len = nbits;
    ext_sel = ext;
    idle(4);
    if (ext) begin
      rx_en = 1;
      idle(2);
      for (int i = 0; i < len; i++) begin
        sdata_in = bits[i]; sclk_in = 0; idle(HP);
        sclk_in = 1; idle(HP);
      end
      idle(6);
    end else begin
      sdata_in = bits[0];
      rx_en = 1;
      for (int i = 0; i < len; i++) begin
        @(posedge sclk_out);
        if (i < len - 1) begin
          @(negedge sclk_out);
          @(negedge clk);
          sdata_in = bits[i + 1];
        end
      end
      idle(6);
    end
  endtask

  task automatic frame_full(input bit ext, input logic [7:0] d, input logic pb, input logic sb);
    send(ext, d, pb, sb, 10);
    rx_en = 0;
    idle(2);
  endtask

  task automatic model_frame(input logic [7:0] d, input logic pb, input logic sb);
    logic pe, fe;
    pe = par_en && (pb != good_pbit(d, par_odd));
    fe = stop_en && !sb;
    if (m_full) m_ovr = 1;
    else if (pe || fe) begin
      if (pe) m_per = 1;
      if (fe) m_fer = 1;
    end else begin
      m_data = d; m_full = 1;
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R3 data"}, rd_data, m_data);
    chk({tag, " R3 full"}, full, m_full);
    chk({tag, " R5 ovr"}, ovr, m_ovr);
    chk({tag, " R12 fer"}, fer, m_fer);
    chk({tag, " R11 per"}, per, m_per);
    chk({tag, " R4 irq_rx"}, irq_rx, rie & m_full);
    chk({tag, " R6 irq_err"}, irq_err, rie & (m_ovr | m_fer | m_per));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle(3);
    rst_n = 1;
    idle(2);
    // R1 reset values
    chk("R1 rd_data", rd_data, 0);
    chk("R1 flags", {full, ovr, fer, per}, 0);
    chk("R1 sclk_out", sclk_out, 0);
    chk("R1 irqs", {irq_rx, irq_err}, 0);

    // R2 R10 external clock frame, LSB first
    rie = 1;
    frame_full(1, 8'hA5, 0, 1); model_frame(8'hA5, 0, 1);
    check_all("R2 R10 ext");

    // R8 full stays through waiting and a foreign clear
    idle(50);
    clr_ovr = 1; idle(1); clr_ovr = 0; idle(1);
    chk("R8 full sticky", full, 1);

    // R5 overrun
    frame_full(1, 8'h3C, 0, 1); model_frame(8'h3C, 0, 1);
    check_all("R5 overrun");

    // R7 lockout: clear ovr only, full still set
    clr_ovr = 1; idle(1); clr_ovr = 0; m_ovr = 0; idle(1);
    frame_full(1, 8'h11, 0, 1);
    check_all("R7 locked");
    // R9 generated clock stays low while locked
    ext_sel = 0; rx_en = 1;
    begin
      int rises = 0;
      for (int k = 0; k < 10 * DIV; k++) begin idle(1); rises += sclk_out; end
      chk("R9 clock stopped when locked", rises, 0);
    end
    rx_en = 0; idle(2);

    // release and use generated clock
    clr_full = 1; idle(1); clr_full = 0; m_full = 0; idle(2);
    frame_full(0, 8'h5A, 0, 1); model_frame(8'h5A, 0, 1);
    check_all("R9 R3 internal");

    // R11 parity good then bad
    par_en = 1; par_odd = 1;
    clear_all();
    frame_full(1, 8'h37, good_pbit(8'h37, 1), 1); model_frame(8'h37, good_pbit(8'h37, 1), 1);
    check_all("R11 odd good");
    clear_all();
    frame_full(1, 8'h81, ~good_pbit(8'h81, 1), 1); model_frame(8'h81, ~good_pbit(8'h81, 1), 1);
    check_all("R11 odd bad");
    chk("R11 per set", per, 1);
    clear_all();
    par_odd = 0;
    frame_full(0, 8'h0F, good_pbit(8'h0F, 0), 1); model_frame(8'h0F, good_pbit(8'h0F, 0), 1);
    check_all("R11 even good");
    par_en = 0;

    // R12 stop bit fault
    stop_en = 1;
    clear_all();
    frame_full(1, 8'hE7, 0, 0); model_frame(8'hE7, 0, 0);
    check_all("R12 stop fault");
    chk("R12 fer set", fer, 1);
    clear_all();
    stop_en = 0;

    // R13 partial frame dropped by rx_en low
    send(1, 8'hFF, 0, 1, 4);
    rx_en = 0; idle(4);
    check_all("R13 partial kept");
    frame_full(1, 8'hC3, 0, 1); model_frame(8'hC3, 0, 1);
    check_all("R13 after partial");

    // R9 toggle rate: 4 rising edges in 8*DIV cycles
    clear_all();
    ext_sel = 0; rx_en = 1;
    begin
      int rises = 0;
      logic prev = 0;
      for (int k = 0; k < 8 * DIV; k++) begin
        idle(1);
        if (sclk_out && !prev) rises++;
        prev = sclk_out;
      end
      chk("R9 rising edges", rises, 4);
    end
    rx_en = 0; idle(2);
    check_all("R13 after abort");

    // R4 disabled requests
    frame_full(1, 8'h42, 0, 1); model_frame(8'h42, 0, 1);
    rie = 0; idle(1);
    chk("R4 irq_rx off", irq_rx, 0);
    frame_full(1, 8'h24, 0, 1); model_frame(8'h24, 0, 1);
    chk("R6 irq_err off", irq_err, 0);
    check_all("R4 R6 rie off");

    // random frames
    for (int n = 0; n < 40; n++) begin
      logic [7:0] d;
      logic pb, sb;
      int inj;
      bit ext;
      d = 8'($urandom);
      ext = bit'($urandom % 2);
      par_en = 1'($urandom); par_odd = 1'($urandom); stop_en = 1'($urandom);
      rie = 1'($urandom);
      inj = $urandom % 4;
      if (m_ovr || m_fer || m_per) clear_all();
      else if ($urandom % 3 != 0) begin
        clr_full = 1; idle(1); clr_full = 0; m_full = 0; idle(1);
      end
      pb = good_pbit(d, par_odd) ^ (inj == 0);
      sb = !(inj == 1);
      frame_full(ext, d, pb, sb);
      model_frame(d, pb, sb);
      check_all("R2 R3 R5 R11 R12 random");
    end

    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule